// File: doc/BRIEF.md
# Programmable Parallel Ports with Strobed Handshake

The block provides two 8-bit parallel ports, A and B, and a 6-bit port C, all set up through one command register. Ports A and B each have a direction bit. Port C runs as a plain input, as a plain output, or as the handshake lines for ports A and B. In handshake mode each of A and B uses one strobe input, one buffer-full output and one interrupt output on port C.

A host reaches the block through a simple register interface: a two-bit register select, a write strobe with write data, and a read strobe. Read data comes back one cycle later from a register. The status register is read at the same select as the command register. It shows the interrupt request, buffer-full flag and interrupt enable of each port. Reading a strobed input port clears its handshake flags. Writing a strobed output port starts a new transfer.

Top module: `prog_ports`

## Requirements
- R1: A synchronous active-high reset clears the command register, both handshake channels and all port latches. All three ports are then inputs (`pa_oe`, `pb_oe` and `pc_oe` are all zero), and a status read returns 0x00.
- R2: Command bit 0 sets the direction of port A and bit 1 sets the direction of port B (1 = output). An output port drives its latch on its pins and raises its oe. A read of an output port returns the latch. A read of a plain input port returns the live pins. The latch can still be written while the port is an input.
- R3: Command bits 3:2 set the port C mode: 00 is input (read returns `pc_in`, `pc_oe`=0), 01 is output (pins and reads carry the low 6 bits of the port C latch, `pc_oe`=all ones), and 10 or 11 is handshake.
- R4: In handshake mode `pc_oe` is 011011 binary. Bit 0 is the port A interrupt, bit 1 is A buffer-full, bit 2 is the A strobe input, bit 3 is the B interrupt, bit 4 is B buffer-full and bit 5 is the B strobe input. A port C read returns {00, pc_in[5], B buffer-full, B interrupt, pc_in[2], A buffer-full, A interrupt}.
- R5: For a port that is an input in handshake mode, a falling strobe captures the port pins and sets buffer-full. A rising strobe sets the interrupt when that port's enable is 1. A read of the port returns the captured byte.
- R6: A read of a strobed input port clears its interrupt and its buffer-full flag.
- R7: For a port that is an output in handshake mode, a write to the port sets buffer-full and clears its interrupt. A falling strobe clears buffer-full, and a rising strobe sets the interrupt when enabled.
- R8: Command bit 4 enables the port A interrupt and bit 5 enables the port B interrupt. When the enable is 0, strobes never set that port's interrupt.
- R9: Status read at select 0 returns bit0 A interrupt, bit1 A buffer-full, bit2 A enable, bit3 B interrupt, bit4 B buffer-full, bit5 B enable, bits 7:6 zero. The select codes are 0 command/status, 1 port A, 2 port B, 3 port C.
- R10: Each strobe passes through a two-flop synchronizer before edge detection. Outside handshake mode, strobe edges and port accesses leave the handshake flags unchanged.
- R11: `rd_data` is loaded only in the cycle after `rd_en` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 cmd/status, 1 A, 2 B, 3 C |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pin input |
| pc_out | output | 6 | Port C pin output |
| pc_oe | output | 6 | Port C per-bit output enable |

## Verification
The bench changes the port A pins after the falling strobe and before the rising one, so a design that captures on the wrong edge returns the later byte. It runs a strobe cycle with the interrupt enable off, where a design that ignores the enable would show an interrupt in status. It reads the strobed input port and checks that both flags drop, and it writes a strobed output port after an acknowledge to show that a write clears the interrupt and raises buffer-full again. It also toggles a strobe outside handshake mode, where a design that leaves edge detection active would change status.

// File: rtl/pp_pkg.sv
package pp_pkg;

  localparam int CMD_W = 8;
  localparam int PC_W  = 6;
  localparam int NCH   = 2;

  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_A   = 2'd1;
  localparam logic [1:0] SEL_B   = 2'd2;
  localparam logic [1:0] SEL_C   = 2'd3;

  // bit positions of the handshake lines on port C
  localparam int HS_A_INTR = 0;
  localparam int HS_A_BF   = 1;
  localparam int HS_A_STB  = 2;
  localparam int HS_B_INTR = 3;
  localparam int HS_B_BF   = 4;
  localparam int HS_B_STB  = 5;

  localparam logic [PC_W-1:0] HS_OE_MASK = 6'b011011;

  typedef enum logic [1:0] {
    PCM_IN   = 2'b00,
    PCM_OUT  = 2'b01,
    PCM_HS   = 2'b10,
    PCM_HS_X = 2'b11
  } pc_mode_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       ien_b;
    logic       ien_a;
    pc_mode_e   pc_mode;
    logic       dir_b;
    logic       dir_a;
  } cmd_t;

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {(STAGES+1){IDLE}};
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign fall =  sh[STAGES] & ~sh[STAGES-1];
  assign rise = ~sh[STAGES] &  sh[STAGES-1];
endmodule

// File: rtl/pp_hs_chan.sv
module pp_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         dir_out,
  input  logic         ien,
  input  logic         stb_fall,
  input  logic         stb_rise,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  input  logic [W-1:0] pin,
  output logic         bf,
  output logic         intr,
  output logic [W-1:0] cap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bf   <= 1'b0;
      intr <= 1'b0;
      cap  <= '0;
    end else if (en) begin
      if (dir_out) begin
        // output side: strobe acknowledges, a new write wins over it
        if (stb_fall) bf <= 1'b0;
        if (cpu_wr) begin
          bf   <= 1'b1;
          intr <= 1'b0;
        end
        if (stb_rise && ien) intr <= 1'b1;
      end else begin
        // input side: host read clears, a strobe event in the same cycle wins
        if (cpu_rd) begin
          bf   <= 1'b0;
          intr <= 1'b0;
        end
        if (stb_fall) begin
          bf  <= 1'b1;
          cap <= pin;
        end
        if (stb_rise && ien) intr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prog_ports.sv
module prog_ports
  import pp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic              pb_oe,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe
);
  localparam int PAD_C = DATA_W - PC_W;
  localparam int PAD_S = DATA_W - CMD_W;

  cmd_t                        cmd_q;
  logic [DATA_W-1:0]           lat_a, lat_b;
  logic [PC_W-1:0]             lat_c;
  logic                        hs_mode;

  logic [NCH-1:0]              stb_raw, fall, rise;
  logic [NCH-1:0]              dir_out, ien, cpu_rd, cpu_wr;
  logic [NCH-1:0]              intr_q, bf_q;
  logic [NCH-1:0][DATA_W-1:0]  pin_v, cap_v;

  logic [DATA_W-1:0]           rd_next;
  logic [CMD_W-1:0]            status;
  logic [PC_W-1:0]             pc_hs_view;

  assign hs_mode = cmd_q.pc_mode[1];

  // ---------------- host write side ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        SEL_CMD: cmd_q <= cmd_t'(wr_data[CMD_W-1:0]);
        SEL_A:   lat_a <= wr_data;
        SEL_B:   lat_b <= wr_data;
        default: lat_c <= wr_data[PC_W-1:0];
      endcase
    end
  end

  // ---------------- handshake channels ----------------
  assign stb_raw = {pc_in[HS_B_STB], pc_in[HS_A_STB]};
  assign dir_out = {cmd_q.dir_b, cmd_q.dir_a};
  assign ien     = {cmd_q.ien_b, cmd_q.ien_a};
  assign pin_v   = {pb_in, pa_in};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      localparam logic [1:0] MY_SEL = SEL_A + 2'(g);

      assign cpu_rd[g] = rd_en && (reg_sel == MY_SEL);
      assign cpu_wr[g] = wr_en && (reg_sel == MY_SEL);

      pp_sync #(.STAGES(SYNC_STAGE), .IDLE(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (stb_raw[g]),
        .fall (fall[g]),
        .rise (rise[g])
      );

      pp_hs_chan #(.W(DATA_W)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .en       (hs_mode),
        .dir_out  (dir_out[g]),
        .ien      (ien[g]),
        .stb_fall (fall[g]),
        .stb_rise (rise[g]),
        .cpu_rd   (cpu_rd[g]),
        .cpu_wr   (cpu_wr[g]),
        .pin      (pin_v[g]),
        .bf       (bf_q[g]),
        .intr     (intr_q[g]),
        .cap      (cap_v[g])
      );
    end
  endgenerate

  // ---------------- pin drive ----------------
  assign pa_out = lat_a;
  assign pa_oe  = cmd_q.dir_a;
  assign pb_out = lat_b;
  assign pb_oe  = cmd_q.dir_b;

  always_comb begin
    pc_hs_view            = '0;
    pc_hs_view[HS_A_INTR] = intr_q[0];
    pc_hs_view[HS_A_BF]   = bf_q[0];
    pc_hs_view[HS_B_INTR] = intr_q[1];
    pc_hs_view[HS_B_BF]   = bf_q[1];
  end

  always_comb begin
    case (cmd_q.pc_mode)
      PCM_IN: begin
        pc_out = lat_c;
        pc_oe  = '0;
      end
      PCM_OUT: begin
        pc_out = lat_c;
        pc_oe  = '1;
      end
      default: begin
        pc_out = pc_hs_view;
        pc_oe  = HS_OE_MASK;
      end
    endcase
  end

  // ---------------- host read side ----------------
  assign status = {2'b00, cmd_q.ien_b, bf_q[1], intr_q[1],
                   cmd_q.ien_a, bf_q[0], intr_q[0]};

  always_comb begin
    case (reg_sel)
      SEL_CMD: rd_next = {{PAD_S{1'b0}}, status};
      SEL_A: begin
        if (cmd_q.dir_a)  rd_next = lat_a;
        else if (hs_mode) rd_next = cap_v[0];
        else              rd_next = pa_in;
      end
      SEL_B: begin
        if (cmd_q.dir_b)  rd_next = lat_b;
        else if (hs_mode) rd_next = cap_v[1];
        else              rd_next = pb_in;
      end
      default: begin
        case (cmd_q.pc_mode)
          PCM_IN:  rd_next = {{PAD_C{1'b0}}, pc_in};
          PCM_OUT: rd_next = {{PAD_C{1'b0}}, lat_c};
          default: rd_next = {{PAD_C{1'b0}},
                              (pc_hs_view | (pc_in & ~HS_OE_MASK))};
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/prog_ports_chk.sv
module prog_ports_chk
  import pp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              pa_oe,
  input logic              pb_oe,
  input logic [PC_W-1:0]   pc_oe,
  input logic              hs_mode,
  input logic              ien_a,
  input logic              ien_b,
  input logic [NCH-1:0]    intr_q,
  input logic [NCH-1:0]    bf_q,
  input logic [NCH-1:0]    fall,
  input logic [NCH-1:0]    rise
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!pa_oe && !pb_oe && pc_oe == '0 && intr_q == '0 && bf_q == '0));

  p_rd_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (hs_mode && !pa_oe && rd_en && reg_sel == SEL_A && !fall[0] && !rise[0])
      |=> (!intr_q[0] && !bf_q[0]));

  p_wr_sets_bf_r7: assert property (@(posedge clk) disable iff (rst)
    (hs_mode && pb_oe && wr_en && reg_sel == SEL_B) |=> bf_q[1]);

  p_no_intr_a_r8: assert property (@(posedge clk) disable iff (rst)
    !ien_a |=> !$rose(intr_q[0]));

  p_no_intr_b_r8: assert property (@(posedge clk) disable iff (rst)
    !ien_b |=> !$rose(intr_q[1]));

  p_flags_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !hs_mode |=> ($stable(intr_q) && $stable(bf_q)));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

bind prog_ports prog_ports_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .reg_sel (reg_sel),
  .rd_data (rd_data),
  .pa_oe   (pa_oe),
  .pb_oe   (pb_oe),
  .pc_oe   (pc_oe),
  .hs_mode (hs_mode),
  .ien_a   (cmd_q.ien_a),
  .ien_b   (cmd_q.ien_b),
  .intr_q  (intr_q),
  .bf_q    (bf_q),
  .fall    (fall),
  .rise    (rise)
);

// File: tb/prog_ports_tb.sv
`timescale 1ns/1ps
module prog_ports_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] pa_in = 8'h3C, pa_out;
  logic [7:0] pb_in = 8'hA5, pb_out;
  logic       pa_oe, pb_oe;
  logic [5:0] pc_in = 6'h2D, pc_out, pc_oe;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  prog_ports u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // {is_write, 0, sel[1:0], data[7:0], expected[7:0]}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    20'h1_00_3C, 20'h2_00_A5, 20'h3_00_2D, 20'h9_5A_00,
    20'h1_00_3C, 20'h8_01_00, 20'h1_00_5A, 20'hA_96_00,
    20'h2_00_A5, 20'h8_07_00, 20'h2_00_96, 20'hB_FF_00,
    20'h3_00_3F, 20'h0_00_00, 20'h8_04_00, 20'h1_00_3C
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] sel, output logic [7:0] q);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
    check("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
    check("R1 pc_oe", {2'd0, pc_oe}, 8'h00);
    do_rd(2'd0, q); check("R1 status", q, 8'h00);

    // R2/R3/R11 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) do_wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        do_rd(VEC[i][17:16], q);
        check($sformatf("R2/R3 vector %0d", i), q, VEC[i][7:0]);
      end
    end
    check("R3 pc_oe out mode", {2'd0, pc_oe}, 8'h3F);
    check("R3 pc_out out mode", {2'd0, pc_out}, 8'h3F);
    check("R2 pa_oe input", {7'd0, pa_oe}, 8'h00);
    do_wr(2'd0, 8'h03);
    check("R2 pa_out", pa_out, 8'h5A);
    check("R2 pb_out", pb_out, 8'h96);
    check("R2 pb_oe", {7'd0, pb_oe}, 8'h01);

    // R11 read data held while rd_en low
    do_wr(2'd0, 8'h00);
    do_rd(2'd1, q);
    pa_in = 8'h99;
    repeat (3) @(negedge clk);
    check("R11 hold", rd_data, 8'h3C);
    pa_in = 8'h3C;

    // Port A strobed input, interrupt enabled
    do_wr(2'd0, 8'h18);
    check("R4 pc_oe hs", {2'd0, pc_oe}, 8'h1B);
    do_rd(2'd0, q); check("R9 status ien A", q, 8'h04);
    pa_in = 8'h77; pc_in[2] = 1'b0; settle();
    check("R5 bf set on fall", {6'd0, pc_out[1:0]}, 8'h02);
    pa_in = 8'h11; pc_in[2] = 1'b1; settle();
    check("R5 intr on rise", {6'd0, pc_out[1:0]}, 8'h03);
    do_rd(2'd3, q); check("R4 port C hs read", q, 8'h27);
    do_rd(2'd0, q); check("R9 status A full", q, 8'h07);
    do_rd(2'd1, q); check("R5 captured byte", q, 8'h77);
    do_rd(2'd0, q); check("R6 read clears A", q, 8'h04);
    check("R6 pins clear", {6'd0, pc_out[1:0]}, 8'h00);

    // Port B strobed input, interrupt disabled
    do_wr(2'd0, 8'h08);
    pb_in = 8'h4E; pc_in[5] = 1'b0; settle();
    pc_in[5] = 1'b1; settle();
    do_rd(2'd0, q); check("R8 no intr when disabled", q, 8'h10);
    do_rd(2'd2, q); check("R5 B captured", q, 8'h4E);
    do_rd(2'd0, q); check("R6 read clears B", q, 8'h00);

    // Port B strobed output, interrupt enabled
    do_wr(2'd0, 8'h2A);
    do_wr(2'd2, 8'hC3);
    check("R7 pb_out", pb_out, 8'hC3);
    check("R7 bf on write", {7'd0, pc_out[4]}, 8'h01);
    pc_in[5] = 1'b0; settle();
    check("R7 bf cleared by strobe", {7'd0, pc_out[4]}, 8'h00);
    pc_in[5] = 1'b1; settle();
    check("R7 intr on rise", {7'd0, pc_out[3]}, 8'h01);
    do_rd(2'd0, q); check("R9 status B intr", q, 8'h28);
    do_wr(2'd2, 8'h3C);
    do_rd(2'd0, q); check("R7 write clears intr", q, 8'h30);

    // R10 strobes ignored outside handshake mode (flags hold)
    do_wr(2'd0, 8'h14);
    do_rd(2'd0, q); check("R10 status before", q, 8'h14);
    pc_in[2] = 1'b0; pa_in = 8'h81; settle();
    pc_in[2] = 1'b1; settle();
    do_rd(2'd0, q); check("R10 status unchanged", q, 8'h14);
    do_rd(2'd1, q); check("R10 live pins", q, 8'h81);

    // R1 reset in the middle of operation
    do_wr(2'd0, 8'h3B);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R1 oe after reset", {pa_oe, pb_oe, pc_oe}, 8'h00);
    check("R1 pc_out after reset", {2'd0, pc_out}, 8'h00);
    do_rd(2'd0, q); check("R1 status after reset", q, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule